// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns the pins of one or more 8-bit general-purpose input ports into interrupt requests. Each pin has its own choice of level or edge sensing and its own polarity. A per-pin enable masks the pin. A per-pin debounce filter can be placed in front of the detector. Edge events are held until software acknowledges them with a per-pin end-of-interrupt mask. Each port drives a single interrupt line that is the OR of its status bits.

Software configures a port through a simple write strobe and reads it through a combinational read port. The address is `{port, select}`: the upper bits pick the port and the low three bits pick the register. Pin inputs pass through a two-flop synchroniser before they reach the filter and the detector, so asynchronous pins may be connected directly. The debounce filter samples on a shared strobe, `smp_tick`, so one divider can pace the filters of every port.

Top module: `gpirq_unit`

## Requirements
- R1: After reset every register of every port reads 0, every status bit is 0 and every `irq_o` bit is 0.
- R2: The low three address bits select the register: 0 sense mode, 1 polarity, 2 end-of-interrupt, 3 enable, 4 debounce. Writes to selects 0, 1, 3 and 4 read back as written. Select 2 always reads 0. Select 5 reads the status. Selects 6 and 7 read 0 and ignore writes.
- R3: When a pin's mode bit is 0 the pin is level sensed. Its status bit equals enable AND (synchronised pin == polarity bit). A polarity of 1 means high and 0 means low. The status is not held: it follows the pin with a delay of three clock edges.
- R4: When a pin's mode bit is 1 and its polarity bit is 1, a rising edge on an enabled pin sets a held pending bit. The status shows it from the fourth clock edge after the pin changes, and it stays after the pin returns.
- R5: When a pin's mode bit is 1 and its polarity bit is 0, a falling edge on an enabled pin sets the held pending bit in the same way.
- R6: Writing select 2 clears the held pending bit of every pin whose data bit is 1. Pins whose data bit is 0 are left unchanged.
- R7: If a new qualifying edge arrives in the same cycle as an end-of-interrupt write for that pin, the pending bit stays set.
- R8: A pin whose enable bit is 0 is never reported. Clearing the enable drops a held pending bit, and edges that occur while the pin is disabled are not held.
- R9: With a pin's debounce bit set, a new level reaches the detector only after `DEB_CNT` consecutive `smp_tick` samples (3 by default) have all differed from the accepted level. Shorter glitches are ignored. With the bit clear, the filter is bypassed.
- R10: `irq_o[p]` is the OR of the eight status bits of port p, and the ports operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_tick | input | 1 | Sample strobe for the debounce filters |
| pins_i | input | NPORTS*8 | Pin inputs; port p occupies bits 8p+7..8p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | PW+3 | Write address {port, select} |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_addr | input | PW+3 | Read address {port, select} |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq_o | output | NPORTS | Combined interrupt line of each port |

## Verification
A pin change driven before clock edge k is seen at the synchroniser output after edge k+1. It reaches the detector after edge k+2, which is when a level status responds. A held edge status appears one edge later, at k+3. Register writes and end-of-interrupt writes take effect at the edge that samples them. The bench keeps a behavioural model that advances on the same edges and compares every `irq_o` bit and the read data a few nanoseconds after each edge, so every result is checked in the exact cycle it is due. End-of-interrupt writes are swept across several offsets relative to a new edge, so one of them lands in the collision cycle of R7.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int PORT_PINS = 8;
  localparam int SEL_W     = 3;

  typedef logic [PORT_PINS-1:0] pinvec_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_MODE = 3'd0,
    SEL_POL  = 3'd1,
    SEL_EOI  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_FILT = 3'd4,
    SEL_STAT = 3'd5
  } regsel_e;

  // Per-pin edge qualification: rising where pol is 1, falling where pol is 0.
  function automatic pinvec_t edge_seen(pinvec_t cur, pinvec_t prev, pinvec_t pol);
    return (cur & ~prev & pol) | (~cur & prev & ~pol);
  endfunction

  // Per-pin level qualification: active when the pin equals its polarity bit.
  function automatic pinvec_t level_seen(pinvec_t cur, pinvec_t pol);
    return ~(cur ^ pol);
  endfunction

  // Held edge bits: a fresh hit beats an acknowledge; disable drops everything.
  function automatic pinvec_t pend_next(pinvec_t pend, pinvec_t hit, pinvec_t ack, pinvec_t en);
    return en & (hit | (pend & ~ack));
  endfunction
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpirq_filter.sv
module gpirq_filter #(
  parameter int DEB_CNT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic bypass,
  input  logic din,
  output logic dout
);
  localparam int CW = (DEB_CNT < 2) ? 1 : $clog2(DEB_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CNT - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      run  <= '0;
    end else if (bypass) begin
      dout <= din;
      run  <= '0;
    end else if (strobe) begin
      if (din == dout) begin
        run <= '0;
      end else if (run == LAST) begin
        dout <= din;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpirq_port.sv
module gpirq_port
  import gpirq_pkg::*;
#(
  parameter int DEB_CNT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  pinvec_t          pins,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  pinvec_t          wdata,
  output pinvec_t          mode_q,
  output pinvec_t          pol_q,
  output pinvec_t          en_q,
  output pinvec_t          filt_q,
  output pinvec_t          stat,
  output pinvec_t          pend_q,
  output pinvec_t          hit,
  output pinvec_t          ack,
  output pinvec_t          flt,
  output pinvec_t          synced
);
  pinvec_t prev_q;

  gpirq_sync #(.W(PORT_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins),
    .q   (synced)
  );

  for (genvar j = 0; j < PORT_PINS; j++) begin : g_pin
    gpirq_filter #(.DEB_CNT(DEB_CNT)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .bypass (~filt_q[j]),
      .din    (synced[j]),
      .dout   (flt[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      filt_q <= '0;
    end else if (we) begin
      case (regsel_e'(wsel))
        SEL_MODE: mode_q <= wdata;
        SEL_POL:  pol_q  <= wdata;
        SEL_EN:   en_q   <= wdata;
        SEL_FILT: filt_q <= wdata;
        default:  ;
      endcase
    end
  end

  assign ack = (we && (regsel_e'(wsel) == SEL_EOI)) ? wdata : '0;
  assign hit = en_q & mode_q & edge_seen(flt, prev_q, pol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= flt;
      pend_q <= pend_next(pend_q, hit, ack, en_q);
    end
  end

  assign stat = en_q & ((mode_q & pend_q) | (~mode_q & level_seen(flt, pol_q)));
endmodule

// File: rtl/gpirq_unit.sv
module gpirq_unit
  import gpirq_pkg::*;
#(
  parameter int NPORTS  = 2,
  parameter int DEB_CNT = 3,
  localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int AW     = PW + SEL_W,
  localparam int NPINS  = NPORTS * PORT_PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_tick,
  input  logic [NPINS-1:0]     pins_i,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [PORT_PINS-1:0] wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [PORT_PINS-1:0] rd_data,
  output logic [NPORTS-1:0]    irq_o
);
  pinvec_t mode_a [NPORTS];
  pinvec_t pol_a  [NPORTS];
  pinvec_t en_a   [NPORTS];
  pinvec_t filt_a [NPORTS];
  pinvec_t stat_a [NPORTS];

  // Flattened internal events, brought out for the checker.
  logic [NPINS-1:0] hit_all, ack_all, pend_all, en_all, flt_all, sync_all, filt_all;

  logic [PW-1:0]    wr_port;
  logic [SEL_W-1:0] wr_sel;
  assign wr_port = wr_addr[AW-1:SEL_W];
  assign wr_sel  = wr_addr[SEL_W-1:0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    pinvec_t pend_w, hit_w, ack_w, flt_w, sync_w;

    gpirq_port #(.DEB_CNT(DEB_CNT)) u_port (
      .clk    (clk),
      .rst    (rst),
      .strobe (smp_tick),
      .pins   (pins_i[p*PORT_PINS +: PORT_PINS]),
      .we     (wr_en && (wr_port == PW'(p))),
      .wsel   (wr_sel),
      .wdata  (wr_data),
      .mode_q (mode_a[p]),
      .pol_q  (pol_a[p]),
      .en_q   (en_a[p]),
      .filt_q (filt_a[p]),
      .stat   (stat_a[p]),
      .pend_q (pend_w),
      .hit    (hit_w),
      .ack    (ack_w),
      .flt    (flt_w),
      .synced (sync_w)
    );

    assign irq_o[p] = |stat_a[p];
    assign hit_all [p*PORT_PINS +: PORT_PINS] = hit_w;
    assign ack_all [p*PORT_PINS +: PORT_PINS] = ack_w;
    assign pend_all[p*PORT_PINS +: PORT_PINS] = pend_w;
    assign en_all  [p*PORT_PINS +: PORT_PINS] = en_a[p];
    assign flt_all [p*PORT_PINS +: PORT_PINS] = flt_w;
    assign sync_all[p*PORT_PINS +: PORT_PINS] = sync_w;
    assign filt_all[p*PORT_PINS +: PORT_PINS] = filt_a[p];
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rd_addr[AW-1:SEL_W] == PW'(p)) begin
        case (regsel_e'(rd_addr[SEL_W-1:0]))
          SEL_MODE: rd_data = mode_a[p];
          SEL_POL:  rd_data = pol_a[p];
          SEL_EN:   rd_data = en_a[p];
          SEL_FILT: rd_data = filt_a[p];
          SEL_STAT: rd_data = stat_a[p];
          default:  rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpirq_unit_chk.sv
module gpirq_unit_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_tick,
  input logic [N-1:0] hit_all,
  input logic [N-1:0] ack_all,
  input logic [N-1:0] pend_all,
  input logic [N-1:0] en_all,
  input logic [N-1:0] flt_all,
  input logic [N-1:0] sync_all,
  input logic [N-1:0] filt_all
);
  // R6: an acknowledge without a competing edge leaves the pin clear.
  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    |(ack_all & ~hit_all) |=> ((pend_all & $past(ack_all & ~hit_all)) == '0));

  // R7: a qualifying edge always leaves the pin pending, even against an acknowledge.
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    |hit_all |=> ((pend_all & $past(hit_all)) == $past(hit_all)));

  // R4: a held bit survives while enabled and not acknowledged.
  a_r4_pend_holds: assert property (@(posedge clk) disable iff (rst)
    |(pend_all & en_all & ~ack_all) |=>
      ((pend_all & $past(pend_all & en_all & ~ack_all)) == $past(pend_all & en_all & ~ack_all)));

  // R8: a disabled pin holds nothing on the next cycle.
  a_r8_disable_drops: assert property (@(posedge clk) disable iff (rst)
    |(~en_all) |=> ((pend_all & $past(~en_all)) == '0));

  // R9: a filtered pin changes its accepted level only on a sample strobe.
  a_r9_filter_holds: assert property (@(posedge clk) disable iff (rst)
    !smp_tick |=> (((flt_all ^ $past(flt_all)) & $past(filt_all)) == '0));

  // R9: with the filter off the detector sees the synchronised pin one cycle later.
  a_r9_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    |(~filt_all) |=> (((flt_all ^ $past(sync_all)) & $past(~filt_all)) == '0));
endmodule

bind gpirq_unit gpirq_unit_chk #(.N(NPINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_tick (smp_tick),
  .hit_all  (hit_all),
  .ack_all  (ack_all),
  .pend_all (pend_all),
  .en_all   (en_all),
  .flt_all  (flt_all),
  .sync_all (sync_all),
  .filt_all (filt_all)
);

// File: tb/gpirq_unit_test.sv
module gpirq_unit_test;
  localparam int NP  = 2;
  localparam int DEB = 3;
  localparam int AW  = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            smp_tick = 1'b0;
  logic [NP*8-1:0] pins_i = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [7:0]      rd_data;
  logic [NP-1:0]   irq_o;

  gpirq_unit #(.NPORTS(NP), .DEB_CNT(DEB)) uut (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .pins_i(pins_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  bit    done    = 0;
  string tag     = "R1";

  // Behavioural reference state.
  bit [7:0] m_mode[NP], m_pol[NP], m_en[NP], m_filt[NP];
  bit [7:0] m_s1[NP], m_s2[NP], m_flt[NP], m_prev[NP], m_pend[NP];
  int       m_cnt[NP][8];

  function automatic bit [7:0] m_status(int p);
    bit [7:0] s;
    for (int j = 0; j < 8; j++) begin
      if (!m_en[p][j])        s[j] = 0;
      else if (m_mode[p][j])  s[j] = m_pend[p][j];
      else                    s[j] = (m_flt[p][j] == m_pol[p][j]);
    end
    return s;
  endfunction

  function automatic bit [7:0] m_read(bit [AW-1:0] a);
    int p = a[3];
    case (a[2:0])
      3'd0: return m_mode[p];
      3'd1: return m_pol[p];
      3'd3: return m_en[p];
      3'd4: return m_filt[p];
      3'd5: return m_status(p);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_mode[p] = 0; m_pol[p] = 0; m_en[p] = 0; m_filt[p] = 0;
        m_s1[p] = 0; m_s2[p] = 0; m_flt[p] = 0; m_prev[p] = 0; m_pend[p] = 0;
        for (int j = 0; j < 8; j++) m_cnt[p][j] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        for (int j = 0; j < 8; j++) begin
          bit f, pv, s, rise, fall, hitb, ackb;
          f = m_flt[p][j]; pv = m_prev[p][j]; s = m_s2[p][j];
          rise = f && !pv;
          fall = !f && pv;
          hitb = m_en[p][j] && m_mode[p][j] && (m_pol[p][j] ? rise : fall);
          ackb = wr_en && (int'(wr_addr[3]) == p) && (wr_addr[2:0] == 3'd2) && wr_data[j];
          if (!m_en[p][j])  m_pend[p][j] = 0;
          else if (hitb)    m_pend[p][j] = 1;
          else if (ackb)    m_pend[p][j] = 0;
          m_prev[p][j] = f;
          if (!m_filt[p][j]) begin
            m_flt[p][j] = s; m_cnt[p][j] = 0;
          end else if (smp_tick) begin
            if (s == f) m_cnt[p][j] = 0;
            else if (m_cnt[p][j] + 1 >= DEB) begin m_flt[p][j] = s; m_cnt[p][j] = 0; end
            else m_cnt[p][j]++;
          end
          m_s2[p][j] = m_s1[p][j];
          m_s1[p][j] = pins_i[p*8+j];
        end
      end
      if (wr_en) begin
        case (wr_addr[2:0])
          3'd0: m_mode[wr_addr[3]] = wr_data;
          3'd1: m_pol[wr_addr[3]]  = wr_data;
          3'd3: m_en[wr_addr[3]]   = wr_data;
          3'd4: m_filt[wr_addr[3]] = wr_data;
          default: ;
        endcase
      end
    end
    #3;
    if (!rst && !done) begin
      for (int p = 0; p < NP; p++) begin
        vectors++;
        if (irq_o[p] !== |m_status(p)) begin
          errors++;
          $display("FAIL %s irq_o[%0d] cycle %0d: got %b expected %b", (tag == "R10") ? "R10" : tag,
                   p, cyc, irq_o[p], |m_status(p));
        end
      end
      vectors++;
      if (rd_data !== m_read(rd_addr)) begin
        errors++;
        $display("FAIL %s rd_data addr %0d cycle %0d: got %h expected %h", tag, rd_addr, cyc,
                 rd_data, m_read(rd_addr));
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      smp_tick = (cyc % 4 == 0);
    end
  endtask

  task automatic wr(int p, int sel, bit [7:0] d);
    tick();
    wr_en = 1; wr_addr = AW'(p*8 + sel); wr_data = d;
    tick();
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic look(int p, int sel);
    rd_addr = AW'(p*8 + sel);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    // R1: reset state of all registers
    tag = "R1";
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 8; s++) begin look(p, s); tick(2); end

    // R2: readback, EOI reads 0, selects 6 and 7 ignore writes
    tag = "R2";
    wr(1, 0, 8'hA5); wr(1, 1, 8'h3C); wr(1, 4, 8'h0F); wr(1, 6, 8'hFF); wr(1, 7, 8'h77);
    wr(1, 2, 8'hFF);
    for (int s = 0; s < 8; s++) begin look(1, s); tick(2); end
    wr(1, 0, 8'h00); wr(1, 1, 8'h00); wr(1, 4, 8'h00);

    // R3: level sensing, pins 4..7 active high, 0..3 active low
    tag = "R3";
    wr(0, 1, 8'hF0); wr(0, 0, 8'h00); wr(0, 3, 8'hFF);
    look(0, 5);
    tick(5);
    pins_i[7:0] = 8'hFF; tick(6);
    pins_i[7:0] = 8'h5A; tick(1); pins_i[7:0] = 8'hA5; tick(6);
    pins_i[7:0] = 8'h00; tick(6);

    // R4 / R5: edge sensing, pins 0..3 rising, 4..7 falling
    tag = "R4";
    wr(0, 3, 8'h00); wr(0, 0, 8'hFF); wr(0, 1, 8'h0F);
    pins_i[7:0] = 8'hF0; tick(6);
    wr(0, 3, 8'hFF); tick(4);
    pins_i[0] = 1; tick(6); pins_i[0] = 0; tick(6);
    tag = "R5";
    pins_i[4] = 0; tick(6); pins_i[4] = 1; tick(6);

    // R6: acknowledge clears only the named pins
    tag = "R6";
    wr(0, 2, 8'h01); tick(4);
    wr(0, 2, 8'h00); tick(2);
    wr(0, 2, 8'h10); tick(4);

    // R7: acknowledge swept across the arrival cycle of a new edge
    tag = "R7";
    for (int k = 0; k < 6; k++) begin
      pins_i[1] = 1;
      tick(k);
      wr(0, 2, 8'h02);
      tick(4);
      pins_i[1] = 0; tick(5);
      wr(0, 2, 8'h02); tick(2);
    end

    // R8: disable drops held bits, disabled edges not held
    tag = "R8";
    pins_i[2] = 1; tick(6);
    wr(0, 3, 8'hFB); tick(3);
    pins_i[2] = 0; tick(4); pins_i[2] = 1; tick(6);
    wr(0, 3, 8'hFF); tick(6);
    wr(0, 3, 8'h00); tick(4);

    // R9: debounce on port 1 pin 0, pin 1 unfiltered
    tag = "R9";
    wr(1, 0, 8'h00); wr(1, 1, 8'hFF); wr(1, 4, 8'h01); wr(1, 3, 8'h03);
    look(1, 5);
    pins_i[9:8] = 2'b11; tick(5); pins_i[9:8] = 2'b00; tick(20);
    pins_i[9:8] = 2'b11; tick(25);
    pins_i[8] = 0; tick(3); pins_i[8] = 1; tick(20);
    pins_i[9:8] = 2'b00; tick(25);
    wr(1, 4, 8'h00); pins_i[8] = 1; tick(6); pins_i[8] = 0; tick(6);

    // R10: both ports together and independently
    tag = "R10";
    wr(0, 0, 8'h00); wr(0, 1, 8'hFF); wr(0, 3, 8'h80);
    look(0, 5);
    pins_i[15:8] = 8'h02; tick(6);
    pins_i[7:0] = 8'h80; tick(6);
    pins_i[15:8] = 8'h00; tick(6);
    pins_i[7:0] = 8'h40; tick(6);
    pins_i = '0; tick(6);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule